// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire station management bus that a MAC uses to read and write PHY registers. Software packs an entire management frame into one 32-bit command word: start pattern, opcode, PHY address, register number, turnaround and write data. Writing that word starts a transfer. The block sends a 32-bit preamble of ones, then shifts the command word out most significant bit first on the MDIO line, with timing set by a clock it generates on MDC.

For a read, the master releases MDIO from the second turnaround bit onward and samples the 16 data bits the PHY returns. When the last bit finishes, a completion event bit is set and, for reads, the low half of the data register holds the returned value. Software clears the event by writing a one to it. The MDC rate comes from a programmable half-period count. Software normally loads the speed register with twice the rounded-up ratio of the system clock to 5 MHz, which keeps MDC at or below 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous reset, MDC is low, MDIO is not driven, the status register reads 0, and the speed register reads DEF_HALF shifted left by one.
- R2: A frame is 64 bits: 32 ones, then command bits 31 down to 0. One bit is sent per MDC period, and MDIO changes only when MDC falls, so exactly 64 MDC rising edges occur per frame.
- R3: MDC is high for H system cycles and low for H system cycles, where H is speed register bits [DIV_W:1] and a value of 0 is treated as 1. MDC is low while idle.
- R4: A command whose bits [29:28] are not 2'b10 is a write frame, and the master drives MDIO for all 64 bits.
- R5: A command with bits [29:28] = 2'b10 is a read. The master stops driving MDIO from command bit 16 (frame bit 47) through the end of the frame. On the last 16 MDC rising edges it samples MDIO, most significant bit first. After completion, data register [15:0] holds the sampled value and [31:16] holds the command's upper half.
- R6: The edge that accepts a command sets busy (status bit 1). The event bit (status bit 0) sets, and busy clears, exactly 128*H system cycles after that edge, and MDIO is released at the same time.
- R7: Writing the status register with bit 0 set clears the event bit. Writing it with bit 0 clear leaves the event bit unchanged.
- R8: A command register write while busy is ignored. The frame in flight and the data register are unaffected.
- R9: Register addresses: 0 is command/data, 1 is status, 2 is speed. The speed register reads back as {H, 1'b0}. Read data appears on reg_rdata one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The accepting edge of a command starts the count. The event bit and the cleared busy bit are due exactly 128*H edges later, so the bench samples status one cycle before and one cycle after that point and requires 2'b10 and then 2'b01 (register reads add one cycle). An MDC edge is due H cycles after the previous one. The PHY model samples MDC away from the clock edge, times every high and low phase, and records MDIO on each rising edge. It returns read data on falling edges, so the master sees each data bit a full half-period before its sampling edge. Data register contents are compared only after completion, with values computed from the command fields in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int RD_W      = 16;
  localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_RELEASE = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] IDX_SAMPLE  = IDX_W'(PRE_LEN + 16);
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] RA_CMD   = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_SPEED = 2'd2;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim       = (half == '0) ? DIV_W'(1) : half;
  assign wrap      = run && (cnt == lim - 1'b1);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a fresh high phase lasts more than one cycle when H > 1
  assert_mdc_high_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (run && $rose(mdc) && lim > DIV_W'(1)) |=> mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     cmd,
  input  logic            rise_tick,
  input  logic            fall_tick,
  input  logic            mdio_i,
  output logic            busy,
  output logic            done,
  output logic            mdio_o,
  output logic            mdio_oe,
  output logic [RD_W-1:0] rd_val
);
  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     k;
  logic [IDX_W-1:0]     k_nxt;
  logic                 is_rd;

  assign k_nxt = k + 1'b1;
  assign done  = busy && fall_tick && (k == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      k       <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_val  <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      shreg   <= {{PRE_LEN{1'b1}}, cmd};
      k       <= '0;
      is_rd   <= (cmd[29:28] == OP_READ);
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tick && is_rd && (k >= IDX_SAMPLE))
        rd_val <= {rd_val[RD_W-2:0], mdio_i};
      if (fall_tick) begin
        if (k == IDX_LAST) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          k       <= k_nxt;
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
          mdio_o  <= shreg[FRAME_LEN-2];
          mdio_oe <= !(is_rd && (k_nxt >= IDX_RELEASE));
        end
      end
    end
  end

  // R2: MDIO only moves on an MDC falling edge during a frame
  assert_mdio_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_tick) |=> $stable(mdio_o));
  // R6: completion drops busy and releases the line
  assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !mdio_oe));
  // R5: line released during turnaround tail and data of a read
  assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && (k >= IDX_RELEASE)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int DEF_HALF = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             done,
  input  logic [RD_W-1:0]  rd_val,
  output logic             start,
  output logic [DIV_W-1:0] half,
  output logic [31:0]      rdata
);
  localparam int PAD_W = 31 - DIV_W;

  logic [31:0] data_q;
  logic        event_q;

  assign start = we && (addr == RA_CMD) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      event_q <= 1'b0;
      half    <= DIV_W'(DEF_HALF);
      rdata   <= '0;
    end else begin
      if (start)
        data_q <= wdata;
      else if (done && (data_q[29:28] == OP_READ))
        data_q[RD_W-1:0] <= rd_val;

      if (done)
        event_q <= 1'b1;
      else if (we && (addr == RA_STAT) && wdata[0])
        event_q <= 1'b0;

      if (we && (addr == RA_SPEED))
        half <= wdata[DIV_W:1];

      case (addr)
        RA_CMD:   rdata <= data_q;
        RA_STAT:  rdata <= {30'b0, busy, event_q};
        RA_SPEED: rdata <= {{PAD_W{1'b0}}, half, 1'b0};
        default:  rdata <= '0;
      endcase
    end
  end

  // R6: completion always raises the event
  assert_event_set_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> event_q);
  // R8: command writes during a frame leave the data register alone
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && we && addr == RA_CMD) |=> $stable(data_q));
  // R7: writing a zero to the event bit keeps it
  assert_w1c_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (event_q && we && addr == RA_STAT && !wdata[0]) |=> event_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int DEF_HALF = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             start;
  logic             busy;
  logic             done;
  logic             rise_tick;
  logic             fall_tick;
  logic [DIV_W-1:0] half;
  logic [RD_W-1:0]  rd_val;

  mdio_regs #(.DIV_W(DIV_W), .DEF_HALF(DEF_HALF)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .rd_val(rd_val), .start(start),
    .half(half), .rdata(reg_rdata)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .half(half), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(start), .cmd(reg_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_val(rd_val)
  );
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  // PHY model state
  int          k_ph = 0;
  int          per_bad = 0;
  int          cyc = 0;
  int          last_rise = 0;
  int          exp_half = 10;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] resp = '0;
  logic        rd_mode = 1'b0;
  logic        prev_mdc = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] dt);
    return {2'b01, op, pa, ra, 2'b10, dt};
  endfunction

  // PHY model: watches MDC between clock edges, times phases, answers reads
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (mdc && !prev_mdc) begin
        if (k_ph < 64) begin
          cap_o[63-k_ph]  = mdio_o;
          cap_oe[63-k_ph] = mdio_oe;
        end
        if (k_ph > 0 && (cyc - last_rise) != 2*exp_half) per_bad++;
        last_rise = cyc;
        k_ph++;
      end
      if (!mdc && prev_mdc) begin
        if ((cyc - last_rise) != exp_half) per_bad++;
        if (rd_mode && k_ph >= 48 && k_ph < 64) mdio_i = resp[63-k_ph];
        else mdio_i = 1'b1;
      end
      prev_mdc = mdc;
    end
  end

  task automatic run_frame(input logic [31:0] cmd, input int h, input bit interfere);
    logic [63:0] expf;
    logic [63:0] expoe;
    logic [31:0] d;
    logic [31:0] expd;
    int hh;
    hh = (h == 0) ? 1 : h;
    exp_half = hh;
    rd_mode = (cmd[29:28] == 2'b10);
    resp = 16'(32'(cmd[27:23]) * 1237 + 32'(cmd[22:18]) * 331 + 32'h1357);
    k_ph = 0; per_bad = 0; cap_o = '0; cap_oe = '0;
    wr(2'd0, cmd);
    if (interfere) begin
      repeat (64*hh) @(posedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = ~cmd;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd1;
      repeat (64*hh - 1) @(posedge clk);
    end else begin
      repeat (128*hh) @(posedge clk);
    end
    @(negedge clk);
    chk(reg_rdata[1:0] == 2'b10, "R6 busy, no event just before 128*H", 64'(reg_rdata[1:0]), 64'd2);
    @(posedge clk);
    @(negedge clk);
    chk(reg_rdata[1:0] == 2'b01, "R6 event set, busy clear at 128*H", 64'(reg_rdata[1:0]), 64'd1);
    chk(k_ph == 64, "R2 rising edge count", 64'(k_ph), 64'd64);
    chk(per_bad == 0, "R3 MDC phase timing", 64'(per_bad), 64'd0);
    chk(!mdio_oe, "R6 released after frame", 64'(mdio_oe), 64'd0);
    expf = {32'hFFFF_FFFF, cmd};
    if (rd_mode) begin
      expoe = ~64'h1FFFF;
      chk(cap_oe == expoe, "R5 read drive window", cap_oe, expoe);
      chk((cap_o & expoe) == (expf & expoe), "R2 read frame bits", cap_o & expoe, expf & expoe);
    end else begin
      chk(cap_oe == '1, "R4 write driven all bits", cap_oe, '1);
      chk(cap_o == expf, "R2 write frame bits", cap_o, expf);
    end
    rd(2'd0, d);
    expd = rd_mode ? {cmd[31:16], resp} : cmd;
    chk(d == expd, interfere ? "R8 data after ignored write" : "R5 data register", 64'(d), 64'(expd));
    wr(2'd1, 32'd0);
    rd(2'd1, d);
    chk(d[0] == 1'b1, "R7 write zero keeps event", 64'(d[0]), 64'd1);
    wr(2'd1, 32'd1);
    rd(2'd1, d);
    chk(d[0] == 1'b0, "R7 write one clears event", 64'(d[0]), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {62'b0, mdc, mdio_oe}, 64'd0);
    rd(2'd1, d);
    chk(d == 32'd0, "R1 status after reset", 64'(d), 64'd0);
    rd(2'd2, d);
    chk(d == 32'd20, "R1 speed after reset", 64'(d), 64'd20);
    for (int h = 1; h <= 3; h++) begin
      wr(2'd2, 32'((h << 1) | 1));
      rd(2'd2, d);
      chk(d == 32'(h << 1), "R9 speed readback", 64'(d), 64'(h << 1));
      for (int i = 0; i < 3; i++) begin
        logic [4:0] pa;
        logic [4:0] ra;
        pa = 5'((i * 13 + h * 7) % 32);
        ra = 5'((i * 11 + h * 5 + 31 * (i == 2 ? 1 : 0)) % 32);
        run_frame(mk(2'b10, pa, ra, 16'h0000), h, i == 2);
        run_frame(mk(2'b01, ra, pa, 16'(i * 4099 + h * 911)), h, i == 1);
      end
    end
    wr(2'd2, 32'd0);
    rd(2'd2, d);
    chk(d == 32'd0, "R9 speed zero readback", 64'(d), 64'd0);
    run_frame(mk(2'b10, 5'd31, 5'd31, 16'h0000), 0, 1'b0);
    wr(2'd2, 32'd4);
    run_frame(mk(2'b00, 5'd0, 5'd0, 16'hFFFF), 2, 1'b0);
    run_frame(mk(2'b11, 5'd21, 5'd10, 16'h8001), 2, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule